// File: doc/BRIEF.md
# Serial Management Bus Master

This block is a register-driven master for the two-wire PHY management bus (MDC clock, MDIO data). Software prepares one 32-bit command word that names the frame flavour (clause 22 or clause 45), the opcode, the port address, the register or device address and sixteen bits of payload. Setting the start bit in the same write launches the frame. The block divides the system clock down to MDC and shifts out a 64-bit frame. For read-type opcodes it releases the data line during turnaround and collects the sixteen reply bits from the PHY.

Completion shows up in two places. The start bit clears by itself, and a separate status and configuration word carries an idle flag next to the last read result. The same word holds the MDC divider threshold, a choice of which MDC edge launches and which samples, and a small delay that sets how many system clocks after the sampling edge the reply bit is latched. Multi-frame clause 45 accesses (an address frame followed by a data frame) are sequenced by software. Each of those frames is an ordinary launch here.

Top module: `mdio_mgmt_master`

## Requirements
- R1: A write to offset 0x0 while idle with bit 31 set launches one frame. Bit 31 reads 1 until the frame ends and 0 afterwards. Bits 28:0 read back as written and bits 30:29 read 0.
- R2: A frame is 32 ones, then the start code (01 when command bit 28 is 1, 00 when it is 0), the opcode from bits 27:26, the port address from bits 25:21 and the register or device address from bits 20:16, then two turnaround bits and sixteen data bits. Every field goes out most significant bit first, and the frame lasts exactly 64 MDC periods.
- R3: When opcode bit 27 is 0 (a write-type frame), the output enable stays asserted for all 64 bits. The turnaround is sent as 1 then 0, and the data bits are command bits 15:0.
- R4: When opcode bit 27 is 1 (a read-type frame), the output enable drops from the first turnaround bit (bit 46 of the frame) to the end of the frame. The sixteen bits sampled during bits 48 to 63 appear, first bit as MSB, in bits 15:0 of offset 0x4.
- R5: Offset 0x4 bit 16 reads 1 exactly when no frame is running. Bits 15:0 keep their value across write-type frames.
- R6: Offset 0x4 bits 31:24 hold the threshold T. Every MDC half period lasts T+1 system clocks. Between frames MDC rests at the level of offset 0x4 bit 23. Bits 31:20 read back as written.
- R7: With offset 0x4 bit 23 at 0, MDIO changes on MDC falling edges and the reply is sampled on rising edges. With bit 23 at 1, the MDC pin is inverted, so MDIO changes on rising edges and the reply is sampled on falling edges.
- R8: Offset 0x4 bits 22:20 hold L. Each reply bit is latched L system clocks after its sampling edge. Software keeps T+1 greater than L.
- R9: A write to offset 0x0 while a frame runs is ignored: the stored fields keep their values and no second frame follows.
- R10: After reset, offset 0x0 reads 0 and offset 0x4 reads 0x0001_0000. MDC is low and the output enable is released.
- R11: A write to offset 0x0 with bit 31 clear stores the fields and leaves MDC idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the register (0x0 command, 0x4 status and configuration) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mdc | output | 1 | Management clock pin |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bench sweeps every flavour and opcode pair under several divider thresholds and both edge settings. A PHY model reconstructs each frame at the sampling edge, so a misplaced field, a wrong start code or turnaround, or an off-by-one frame length shows up as a bit mismatch. The model drives the complement of each reply bit until exactly L clocks after the sampling edge, so a latch that fires early captures the wrong data. Write-type frames confirm that the last read result survives. A command written mid-frame must leave the running frame, the read-back fields and the MDC pin undisturbed; a design that re-armed would emit a second frame or corrupt the first.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int THR_W      = 8;
  localparam int LAT_W      = 3;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  // Field order matches command bits 28:0.
  typedef struct packed {
    logic        c22;
    logic [1:0]  op;
    logic [4:0]  port;
    logic [4:0]  dev;
    logic [15:0] data;
  } cmd_t;

  function automatic logic op_is_read(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    return cmd_t'(w[28:0]);
  endfunction

  // Whole frame, bit 63 sent first. Read frames carry ones where the line is released.
  function automatic logic [FRAME_BITS-1:0] frame_word(input cmd_t c);
    logic rd;
    rd = op_is_read(c.op);
    return {32'hFFFF_FFFF, 1'b0, c.c22, c.op, c.port, c.dev,
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : c.data};
  endfunction
endpackage

// File: rtl/mdio_mgmt_clkdiv.sv
module mdio_mgmt_clkdiv
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [THR_W-1:0] thr,
  output logic             mdc_int,
  output logic             launch,
  output logic             sample
);
  logic [THR_W-1:0] cnt;
  logic             tick;

  assign tick   = run && (cnt == thr);
  assign sample = tick && !mdc_int;
  assign launch = tick && mdc_int;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt     <= '0;
      mdc_int <= 1'b0;
    end else if (tick) begin
      cnt     <= '0;
      mdc_int <= ~mdc_int;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  cmd_t             cmd,
  input  logic             launch,
  input  logic             sample,
  input  logic [LAT_W-1:0] lat,
  input  logic             mdio_i,
  output logic             busy,
  output logic             rd_frame,
  output logic [IDX_W-1:0] bit_idx,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [15:0]      rx_data
);
  logic [FRAME_BITS-1:0] shreg;
  logic                  last_bit;
  logic                  want;
  logic                  grab;
  logic                  pend;
  logic [LAT_W-1:0]      dcnt;

  assign last_bit = (int'(bit_idx) == FRAME_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_frame <= 1'b0;
      bit_idx  <= '0;
      shreg    <= '1;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      rd_frame <= op_is_read(cmd.op);
      bit_idx  <= '0;
      shreg    <= frame_word(cmd);
    end else if (busy && launch) begin
      if (last_bit) busy <= 1'b0;
      else          bit_idx <= bit_idx + 1'b1;
      shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
    end
  end

  assign mdio_o  = busy ? shreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe = busy && !(rd_frame && int'(bit_idx) >= TA_FIRST);

  // Reply capture, delayed by lat clocks after the sampling edge.
  assign want = busy && rd_frame && sample && int'(bit_idx) >= DATA_FIRST;
  assign grab = (want && lat == '0) || (pend && dcnt == LAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      dcnt    <= '0;
      rx_data <= '0;
    end else begin
      if (want && lat != '0) begin
        pend <= 1'b1;
        dcnt <= lat;
      end else if (pend) begin
        if (dcnt == LAT_W'(1)) pend <= 1'b0;
        dcnt <= dcnt - 1'b1;
      end
      if (grab) rx_data <= {rx_data[14:0], mdio_i};
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam logic [2:0] CMD_OFS = 3'h0;
  localparam logic [2:0] CFG_OFS = 3'h4;

  cmd_t             cmd_q;
  logic [THR_W-1:0] thr_q;
  logic             edge_q;
  logic [LAT_W-1:0] lat_q;
  logic             busy;
  logic             rd_frame;
  logic [IDX_W-1:0] bit_idx;
  logic [15:0]      rx_data;
  logic             mdc_int;
  logic             launch;
  logic             sample;
  logic             wr_cmd;
  logic             wr_cfg;
  logic             fire;
  logic [28:0]      ctl_bits;
  logic             wdata_unused;

  assign wr_cmd       = reg_wr && reg_addr == CMD_OFS && !busy;
  assign wr_cfg       = reg_wr && reg_addr == CFG_OFS;
  assign fire         = wr_cmd && reg_wdata[31];
  assign ctl_bits     = cmd_q;
  assign wdata_unused = ^{reg_wdata[30:29], reg_wdata[19:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      thr_q  <= '0;
      edge_q <= 1'b0;
      lat_q  <= '0;
    end else begin
      if (wr_cmd) cmd_q <= unpack_cmd(reg_wdata);
      if (wr_cfg) begin
        thr_q  <= reg_wdata[31:24];
        edge_q <= reg_wdata[23];
        lat_q  <= reg_wdata[22:20];
      end
    end
  end

  mdio_mgmt_clkdiv u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .thr(thr_q),
    .mdc_int(mdc_int), .launch(launch), .sample(sample)
  );

  mdio_mgmt_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(fire), .cmd(unpack_cmd(reg_wdata)),
    .launch(launch), .sample(sample), .lat(lat_q), .mdio_i(mdio_i),
    .busy(busy), .rd_frame(rd_frame), .bit_idx(bit_idx),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rx_data(rx_data)
  );

  assign mdc = mdc_int ^ edge_q;

  always_comb begin
    case (reg_addr)
      CMD_OFS: reg_rdata = {busy, 2'b00, cmd_q};
      CFG_OFS: reg_rdata = {thr_q, edge_q, lat_q, 3'b000, !busy, rx_data};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_checks.sv
module mdio_mgmt_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        rd_frame,
  input logic [5:0]  bit_idx,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        mdc_int,
  input logic        launch,
  input logic [28:0] ctl_bits,
  input logic [15:0] rx_data
);
  assert_oe_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_frame && bit_idx >= 6'd46) |-> !mdio_oe);

  assert_oe_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_frame) |-> mdio_oe);

  assert_launch_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(launch)) |-> $stable(mdio_o));

  assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl_bits));

  assert_frame_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_idx) == 6'd63);

  assert_mdc_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc_int);

  assert_rx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busy) || !$past(rd_frame)) |-> $stable(rx_data));
endmodule

bind mdio_mgmt_master mdio_mgmt_checks u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_frame(rd_frame),
  .bit_idx(bit_idx), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdc_int(mdc_int),
  .launch(launch), .ctl_bits(ctl_bits), .rx_data(rx_data)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'h0;
  logic [31:0] reg_wdata = 32'h0;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  mdio_mgmt_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // PHY model state
  logic        cfg_edge = 1'b0;
  int          cfg_lat = 0;
  int          cfg_thr = 0;
  logic        mon_en = 1'b0;
  logic        m_prev = 1'b0;
  logic        m_now;
  int          rises = 0, falls = 0, wcnt = 0;
  int          hp_cnt = 0, hp_min = 0, hp_max = 0;
  logic        hp_seen = 1'b0;
  logic [63:0] obs_bits = '0, obs_oe = '0;
  logic [15:0] resp = '0;
  logic        resp_on = 1'b0;
  logic [15:0] last_rd = '0;

  task automatic chk(input bit ok, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  function automatic logic drive_for(input int n);
    logic t;
    if (resp_on && n >= 48 && n <= 63) begin
      t = resp[63 - n];
      return (cfg_lat > 0) ? ~t : t;
    end
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    m_now = mdc ^ cfg_edge;
    if (mon_en) begin
      hp_cnt++;
      if (m_now != m_prev) begin
        if (hp_seen) begin
          if (hp_cnt < hp_min) hp_min = hp_cnt;
          if (hp_cnt > hp_max) hp_max = hp_cnt;
        end
        hp_seen = 1'b1;
        hp_cnt = 0;
      end
      if (m_now && !m_prev) begin
        rises++;
        obs_bits = {obs_bits[62:0], mdio_o};
        obs_oe   = {obs_oe[62:0], mdio_oe};
        if (resp_on && falls >= 48 && falls <= 63 && cfg_lat > 0) wcnt = cfg_lat;
      end
      if (!m_now && m_prev) begin
        falls++;
        mdio_i = drive_for(falls);
      end
      if (wcnt > 0) begin
        wcnt--;
        if (wcnt == 0) mdio_i = resp[63 - falls];
      end
    end
    m_prev = m_now;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog got=%0d exp=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_cfg(input int thr, input logic edg, input int lat);
    logic [31:0] r;
    reg_write(3'h4, {thr[7:0], edg, lat[2:0], 20'h0});
    cfg_thr = thr; cfg_edge = edg; cfg_lat = lat;
    @(negedge clk);
    reg_read(3'h4, r);
    chk(r[31:20] == {thr[7:0], edg, lat[2:0]}, "R6 config readback", 64'(r[31:20]), 64'({thr[7:0], edg, lat[2:0]}));
  endtask

  function automatic logic [31:0] cmd_word(input logic go, input logic c22, input logic [1:0] op,
                                           input logic [4:0] port, input logic [4:0] dev, input logic [15:0] wd);
    return {go, 2'b00, c22, op, port, dev, wd};
  endfunction

  task automatic start_frame(input logic [31:0] w, input logic [15:0] rsp);
    resp = rsp; resp_on = w[27];
    rises = 0; falls = 0; wcnt = 0; obs_bits = '0; obs_oe = '0;
    hp_cnt = 0; hp_seen = 1'b0; hp_min = 1000; hp_max = 0;
    mdio_i = 1'b1;
    mon_en = 1'b1;
    reg_write(3'h0, w);
  endtask

  task automatic finish_frame(input logic [31:0] w, input logic [15:0] rsp);
    logic [31:0] r;
    logic [63:0] exp;
    logic        rd;
    int          n;
    rd  = w[27];
    exp = {32'hFFFF_FFFF, 1'b0, w[28], w[27:26], w[25:21], w[20:16], 2'b10, w[15:0]};
    n = 0;
    reg_read(3'h4, r);
    while (!r[16] && n < 20000) begin
      reg_read(3'h4, r);
      n++;
    end
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    chk(rises == 64, "R2 MDC periods per frame", 64'(rises), 64);
    chk(hp_min == cfg_thr + 1 && hp_max == cfg_thr + 1, "R6 MDC half period", 64'(hp_max), 64'(cfg_thr + 1));
    chk(mdc == cfg_edge, "R6 MDC rest level", 64'(mdc), 64'(cfg_edge));
    if (rd) begin
      chk(obs_oe == {{46{1'b1}}, 18'h0}, "R4 OE released from turnaround", obs_oe, {{46{1'b1}}, 18'h0});
      chk(obs_bits[63:18] == exp[63:18], "R2 read frame header", 64'(obs_bits[63:18]), 64'(exp[63:18]));
      reg_read(3'h4, r);
      chk(r[15:0] == rsp, "R4 R7 R8 read result", 64'(r[15:0]), 64'(rsp));
      last_rd = rsp;
    end else begin
      chk(obs_oe == '1, "R3 OE held for write frame", obs_oe, '1);
      chk(obs_bits == exp, "R3 write frame bits", obs_bits, exp);
      reg_read(3'h4, r);
      chk(r[15:0] == last_rd, "R5 read result kept over write", 64'(r[15:0]), 64'(last_rd));
    end
    chk(r[16] == 1'b1, "R5 idle flag after frame", 64'(r[16]), 1);
    reg_read(3'h0, r);
    chk(r == {1'b0, w[30:0]} && r[30:29] == 2'b00, "R1 start cleared, fields kept", 64'(r), 64'({1'b0, w[30:0]}));
  endtask

  task automatic run_frame(input logic [31:0] w, input logic [15:0] rsp);
    start_frame(w, rsp);
    finish_frame(w, rsp);
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] wa, wb;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    reg_read(3'h0, r);
    chk(r == 32'h0, "R10 command after reset", 64'(r), 0);
    reg_read(3'h4, r);
    chk(r == 32'h0001_0000, "R10 status after reset", 64'(r), 64'h0001_0000);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 pins after reset", 64'({mdc, mdio_oe}), 0);

    // R11 fields stored without a launch
    wa = cmd_word(1'b0, 1'b1, 2'b10, 5'd9, 5'd3, 16'h1234);
    rises = 0; hp_seen = 1'b0; mon_en = 1'b1;
    reg_write(3'h0, wa);
    repeat (40) @(negedge clk);
    mon_en = 1'b0;
    chk(rises == 0, "R11 no frame without start bit", 64'(rises), 0);
    reg_read(3'h0, r);
    chk(r == wa, "R11 fields stored", 64'(r), 64'(wa));
    reg_read(3'h4, r);
    chk(r[16] == 1'b1, "R11 R5 idle kept", 64'(r[16]), 1);

    // Sweep: flavour x opcode x (threshold, edge)
    for (int t = 0; t < 3; t++) begin
      set_cfg((t == 2) ? 3 : t, t == 1, 0);
      for (int k = 0; k < 8; k++) begin
        logic [4:0]  port, dev;
        logic [15:0] wd, rsp;
        port = 5'((k * 7 + t * 5 + 3) & 31);
        dev  = 5'((k * 11 + t * 3 + 5) & 31);
        wd   = 16'hA5C3 ^ 16'(k * 16'h1357 + t);
        rsp  = 16'h3C96 + 16'(k * 16'h0F1D + t * 16'h0101);
        run_frame(cmd_word(1'b1, k[2], k[1:0], port, dev, wd), rsp);
      end
    end

    // R8 latch delay with both edge settings
    set_cfg(9, 1'b0, 5);
    run_frame(cmd_word(1'b1, 1'b1, 2'b10, 5'd17, 5'd2, 16'h0), 16'hB7E1);
    run_frame(cmd_word(1'b1, 1'b0, 2'b11, 5'd4, 5'd30, 16'h0), 16'h4A0F);
    set_cfg(7, 1'b1, 7);
    run_frame(cmd_word(1'b1, 1'b0, 2'b10, 5'd31, 5'd1, 16'h0), 16'h8001);
    run_frame(cmd_word(1'b1, 1'b1, 2'b01, 5'd0, 5'd31, 16'hFFFF), 16'h0);

    // R9 command write while busy is ignored
    set_cfg(1, 1'b0, 0);
    wa = cmd_word(1'b1, 1'b1, 2'b01, 5'd21, 5'd10, 16'hC0DE);
    wb = cmd_word(1'b1, 1'b0, 2'b11, 5'd6, 5'd27, 16'h5555);
    start_frame(wa, 16'h0);
    repeat (20) @(negedge clk);
    reg_write(3'h0, wb);
    reg_read(3'h0, r);
    chk(r == wa, "R9 R1 fields frozen while busy", 64'(r), 64'(wa));
    finish_frame(wa, 16'h0);
    rises = 0; mon_en = 1'b1;
    repeat (60) @(negedge clk);
    mon_en = 1'b0;
    chk(rises == 0, "R9 no second frame", 64'(rises), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule